// File: doc/BRIEF.md
# Multi-Register Transfer Sequencer

This block turns one "move a group of registers to or from memory" instruction into a stream of single-word memory requests. It is given the registers as a 16-bit mask, the base address, the index of the register that holds the base, a direction, an addressing discipline and a write-back flag. After a start pulse it sends one request per cycle. Each request carries the word address, the register index and, for stores, the data read from the register file. The block holds the current request until memory signals ready.

Registers always move in ascending index order, with the lowest index at the lowest address. The discipline only selects where the block of words begins and what the updated base becomes. A stack-style option forces the push/pop pairing: stores lower the base before transferring and loads raise it afterwards. An interrupt can cancel the sequence at any point. Because the base is only committed after the final transfer, a cancelled instruction can simply be started again from the beginning, and the same addresses are then accessed a second time. The block also flags the undefined case where the base register is itself in the list while write-back is requested, and it rejects a base that is not word-aligned.

Top module: `lsm_seq`

## Requirements
- R1: After reset, `busy_o`, `req_valid_o`, `done_o`, `base_we_o`, `conflict_o` and `align_fault_o` are all low.
- R2: Let N be the number of set mask bits. `mode_i` sets the first address: 0 gives base (increment-after), 1 gives base+4 (increment-before), 2 gives base-4N+4 (decrement-after) and 3 gives base-4N (decrement-before). The updated base is base+4N for codes 0 and 1 and base-4N for codes 2 and 3.
- R3: When `fd_i` is 1, `mode_i` is ignored. A store (`load_i`=0) uses code 3 and a load (`load_i`=1) uses code 0.
- R4: Requests name the set mask bits in ascending index order. The first request goes to the first address and each later request is 4 above the one before it, so every request address is word-aligned.
- R5: While `req_valid_o` is high and `mem_ready_i` is low, the request's address, register and direction stay unchanged in the next cycle.
- R6: A store request drives `rf_raddr_o` to the request's register and forwards `rf_rdata_i` on `req_wdata_o`. An accepted load request (valid and ready) raises `rf_we_o` for that cycle only, with `rf_waddr_o` set to the request's register and `rf_wdata_o` set to `mem_rdata_i`.
- R7: `done_o` pulses for exactly one cycle, in the cycle after the last request is accepted. In that cycle `base_we_o` equals the latched write-back flag, and `base_new_o` carries the updated base from R2.
- R8: If the mask is all zeros, `done_o` pulses in the cycle after start. No request is issued and `base_we_o` stays low.
- R9: If the base address has either of its low two bits set, `done_o` and `align_fault_o` pulse together in the cycle after start. No request is issued and `base_we_o` stays low.
- R10: `conflict_o` is high from the cycle after start through the `done_o` cycle if write-back is requested and the mask bit selected by `base_idx_i` is set. Otherwise it is low.
- R11: If `abort_i` is high while busy, the next cycle has `busy_o`, `done_o`, `base_we_o` and `conflict_o` all low. Starting the same instruction again repeats the full request sequence from the first address.
- R12: `busy_o` is high from the cycle after a start with a non-empty mask and an aligned base until the last request is accepted. Requests appear only while busy. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an instruction (accepted only when idle) |
| mask_i | input | 16 | Register selection mask |
| base_i | input | 32 | Base address value |
| base_idx_i | input | 4 | Index of the register holding the base |
| load_i | input | 1 | 1 = load, 0 = store |
| mode_i | input | 2 | Addressing discipline code |
| fd_i | input | 1 | Stack-style discipline override |
| wback_i | input | 1 | Commit the updated base at the end |
| abort_i | input | 1 | Cancel the running sequence |
| mem_ready_i | input | 1 | Memory accepts the current request |
| mem_rdata_i | input | 32 | Load data returned with acceptance |
| rf_rdata_i | input | 32 | Register file read data |
| busy_o | output | 1 | Sequence in progress |
| req_valid_o | output | 1 | Memory request valid |
| req_write_o | output | 1 | Request is a store |
| req_addr_o | output | 32 | Request word address |
| req_reg_o | output | 4 | Register index of the request |
| req_wdata_o | output | 32 | Store data |
| rf_raddr_o | output | 4 | Register file read index |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 4 | Register file write index |
| rf_wdata_o | output | 32 | Register file write data |
| done_o | output | 1 | Completion pulse |
| base_we_o | output | 1 | Commit updated base |
| base_new_o | output | 32 | Updated base value |
| align_fault_o | output | 1 | Misaligned base rejected |
| conflict_o | output | 1 | Base in list with write-back (undefined result) |

## Verification
The bench targets the start-address arithmetic of all four disciplines and of the stack override. A design that mixes up "before" and "after" would shift every address by one word, and one that applies the override backwards would make a push overwrite the caller's frame. Stalls with ready held low are inserted in the middle of a sequence, so a sequencer that advances without acceptance would skip a register or write it twice. An abort is followed by a restart of the same instruction: a design that commits the base early, or resumes in the middle of the list, would give wrong addresses on the second pass. The empty mask, the misaligned base and the base-in-list case are each run, along with a start pulse issued while busy, which a careless design would let restart or corrupt the sequence in progress.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
   typedef enum logic [1:0] {
      LSM_INC_AFTER  = 2'd0,
      LSM_INC_BEFORE = 2'd1,
      LSM_DEC_AFTER  = 2'd2,
      LSM_DEC_BEFORE = 2'd3
   } lsm_mode_e;
endpackage

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
   parameter int W = 16,
   localparam int CNT_W = $clog2(W + 1)
) (
   input  logic [W-1:0]     vec_i,
   output logic [CNT_W-1:0] cnt_o
);
   logic [CNT_W-1:0] part [W+1];

   assign part[0] = '0;
   for (genvar g = 0; g < W; g++) begin : g_acc
      assign part[g+1] = part[g] + CNT_W'(vec_i[g]);
   end
   assign cnt_o = part[W];
endmodule

// File: rtl/lsm_lowbit.sv
module lsm_lowbit #(
   parameter int W = 16,
   localparam int IDX_W = $clog2(W)
) (
   input  logic [W-1:0]     vec_i,
   output logic [IDX_W-1:0] idx_o
);
   always_comb begin
      idx_o = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec_i[i]) idx_o = IDX_W'(i);
      end
   end
endmodule

// File: rtl/lsm_addr_plan.sv
module lsm_addr_plan
   import lsm_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 5,
   parameter int WORD_BYTES = 4,
   localparam int SHIFT     = $clog2(WORD_BYTES)
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  lsm_mode_e         mode_i,
   output logic [ADDR_W-1:0] first_o,
   output logic [ADDR_W-1:0] final_o
);
   logic [ADDR_W-1:0] span;
   logic [ADDR_W-1:0] up;
   logic [ADDR_W-1:0] down;
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   assign span = ADDR_W'(cnt_i) << SHIFT;
   assign up   = base_i + span;
   assign down = base_i - span;

   always_comb begin
      unique case (mode_i)
         LSM_INC_AFTER:  begin first_o = base_i;        final_o = up;   end
         LSM_INC_BEFORE: begin first_o = base_i + STEP; final_o = up;   end
         LSM_DEC_AFTER:  begin first_o = down + STEP;   final_o = down; end
         default:        begin first_o = down;          final_o = down; end
      endcase
   end
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
   import lsm_pkg::*;
#(
   parameter int NUM_REGS   = 16,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 32,
   parameter int WORD_BYTES = 4,
   localparam int IDX_W     = $clog2(NUM_REGS),
   localparam int CNT_W     = $clog2(NUM_REGS + 1),
   localparam int ALIGN_W   = $clog2(WORD_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [NUM_REGS-1:0] mask_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [IDX_W-1:0]  base_idx_i,
   input  logic              load_i,
   input  logic [1:0]        mode_i,
   input  logic              fd_i,
   input  logic              wback_i,
   input  logic              abort_i,
   input  logic              mem_ready_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   input  logic [DATA_W-1:0] rf_rdata_i,
   output logic              busy_o,
   output logic              req_valid_o,
   output logic              req_write_o,
   output logic [ADDR_W-1:0] req_addr_o,
   output logic [IDX_W-1:0]  req_reg_o,
   output logic [DATA_W-1:0] req_wdata_o,
   output logic [IDX_W-1:0]  rf_raddr_o,
   output logic              rf_we_o,
   output logic [IDX_W-1:0]  rf_waddr_o,
   output logic [DATA_W-1:0] rf_wdata_o,
   output logic              done_o,
   output logic              base_we_o,
   output logic [ADDR_W-1:0] base_new_o,
   output logic              align_fault_o,
   output logic              conflict_o
);
   // elaboration-time parameter checks
   if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
      $error("lsm_seq: NUM_REGS must be a power of two, at least 2");
   end
   if (WORD_BYTES < 2 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
      $error("lsm_seq: WORD_BYTES must be a power of two, at least 2");
   end
   if (ADDR_W <= ALIGN_W + CNT_W) begin : g_bad_addr
      $error("lsm_seq: ADDR_W too small for the transfer span");
   end

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   lsm_mode_e          mode_eff;
   logic [CNT_W-1:0]   cnt;
   logic [ADDR_W-1:0]  first_addr;
   logic [ADDR_W-1:0]  final_base;
   logic               misaligned;
   logic               start_acc;
   logic               fire;
   logic               last;
   logic [IDX_W-1:0]   cur_idx;
   logic [NUM_REGS-1:0] rem_nxt;

   logic               busy_q;
   logic [NUM_REGS-1:0] rem_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [ADDR_W-1:0]  nb_q;
   logic               wb_q;
   logic               load_q;
   logic               done_q;
   logic               base_we_q;
   logic               fault_q;
   logic               conflict_q;

   // stack-style override: stores lower first, loads raise after
   assign mode_eff = fd_i ? (load_i ? LSM_INC_AFTER : LSM_DEC_BEFORE)
                          : lsm_mode_e'(mode_i);

   lsm_popcount #(.W(NUM_REGS)) u_cnt (
      .vec_i (mask_i),
      .cnt_o (cnt)
   );

   lsm_addr_plan #(
      .ADDR_W     (ADDR_W),
      .CNT_W      (CNT_W),
      .WORD_BYTES (WORD_BYTES)
   ) u_plan (
      .base_i  (base_i),
      .cnt_i   (cnt),
      .mode_i  (mode_eff),
      .first_o (first_addr),
      .final_o (final_base)
   );

   lsm_lowbit #(.W(NUM_REGS)) u_pick (
      .vec_i (rem_q),
      .idx_o (cur_idx)
   );

   assign misaligned = |base_i[ALIGN_W-1:0];
   assign start_acc  = start_i & ~busy_q;
   assign fire       = busy_q & mem_ready_i;
   assign rem_nxt    = rem_q & (rem_q - NUM_REGS'(1));
   assign last       = (rem_nxt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         rem_q      <= '0;
         addr_q     <= '0;
         nb_q       <= '0;
         wb_q       <= 1'b0;
         load_q     <= 1'b0;
         done_q     <= 1'b0;
         base_we_q  <= 1'b0;
         fault_q    <= 1'b0;
         conflict_q <= 1'b0;
      end else begin
         done_q    <= 1'b0;
         base_we_q <= 1'b0;
         fault_q   <= 1'b0;
         if (start_acc) begin
            conflict_q <= wback_i & mask_i[base_idx_i];
            if (misaligned) begin
               done_q  <= 1'b1;
               fault_q <= 1'b1;
            end else if (mask_i == '0) begin
               done_q <= 1'b1;
            end else begin
               busy_q <= 1'b1;
               rem_q  <= mask_i;
               addr_q <= first_addr;
               nb_q   <= final_base;
               wb_q   <= wback_i;
               load_q <= load_i;
            end
         end else if (busy_q) begin
            if (abort_i) begin
               busy_q     <= 1'b0;
               rem_q      <= '0;
               conflict_q <= 1'b0;
            end else if (mem_ready_i) begin
               rem_q  <= rem_nxt;
               addr_q <= addr_q + STEP;
               if (last) begin
                  busy_q    <= 1'b0;
                  done_q    <= 1'b1;
                  base_we_q <= wb_q;
               end
            end
         end else if (done_q) begin
            conflict_q <= 1'b0;
         end
      end
   end

   assign busy_o        = busy_q;
   assign req_valid_o   = busy_q;
   assign req_write_o   = busy_q & ~load_q;
   assign req_addr_o    = addr_q;
   assign req_reg_o     = cur_idx;
   assign rf_raddr_o    = cur_idx;
   assign req_wdata_o   = rf_rdata_i;
   assign rf_we_o       = fire & load_q;
   assign rf_waddr_o    = cur_idx;
   assign rf_wdata_o    = mem_rdata_i;
   assign done_o        = done_q;
   assign base_we_o     = base_we_q;
   assign base_new_o    = nb_q;
   assign align_fault_o = fault_q;
   assign conflict_o    = conflict_q;
endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk #(
   parameter int NUM_REGS   = 16,
   parameter int ADDR_W     = 32,
   parameter int WORD_BYTES = 4,
   localparam int IDX_W     = $clog2(NUM_REGS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_o,
   input logic              req_valid_o,
   input logic              req_write_o,
   input logic [ADDR_W-1:0] req_addr_o,
   input logic [IDX_W-1:0]  req_reg_o,
   input logic              mem_ready_i,
   input logic              abort_i,
   input logic              rf_we_o,
   input logic              done_o,
   input logic              base_we_o,
   input logic              align_fault_o
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o |-> busy_o); // R12

   AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o |-> (req_addr_o % STEP) == '0); // R4

   AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && !mem_ready_i && !abort_i) |=>
         (req_valid_o && $stable(req_addr_o) && $stable(req_reg_o) && $stable(req_write_o))); // R5

   AST_ASCENDING_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && mem_ready_i && !abort_i) |=>
         (!req_valid_o || (req_addr_o == $past(req_addr_o) + STEP && req_reg_o > $past(req_reg_o)))); // R4

   AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && abort_i) |=> (!busy_o && !done_o && !base_we_o)); // R11

   AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      base_we_o |-> (done_o && !busy_o)); // R7

   AST_LOAD_WRITES_RF: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we_o |-> (req_valid_o && !req_write_o && mem_ready_i)); // R6

   AST_FAULT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      align_fault_o |-> (done_o && !base_we_o && !busy_o)); // R9
endmodule

bind lsm_seq lsm_seq_chk #(
   .NUM_REGS   (NUM_REGS),
   .ADDR_W     (ADDR_W),
   .WORD_BYTES (WORD_BYTES)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .busy_o        (busy_o),
   .req_valid_o   (req_valid_o),
   .req_write_o   (req_write_o),
   .req_addr_o    (req_addr_o),
   .req_reg_o     (req_reg_o),
   .mem_ready_i   (mem_ready_i),
   .abort_i       (abort_i),
   .rf_we_o       (rf_we_o),
   .done_o        (done_o),
   .base_we_o     (base_we_o),
   .align_fault_o (align_fault_o)
);

// File: tb/lsm_seq_tb.sv
module lsm_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [15:0] mask_i = '0;
   logic [31:0] base_i = '0;
   logic [3:0]  base_idx_i = '0;
   logic        load_i = 1'b0;
   logic [1:0]  mode_i = '0;
   logic        fd_i = 1'b0;
   logic        wback_i = 1'b0;
   logic        abort_i = 1'b0;
   logic        mem_ready_i = 1'b1;
   logic [31:0] mem_rdata_i;
   logic [31:0] rf_rdata_i;
   logic        busy_o, req_valid_o, req_write_o, rf_we_o;
   logic [31:0] req_addr_o, req_wdata_o, rf_wdata_o, base_new_o;
   logic [3:0]  req_reg_o, rf_raddr_o, rf_waddr_o;
   logic        done_o, base_we_o, align_fault_o, conflict_o;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   // memory and register-file stand-ins
   assign mem_rdata_i = req_addr_o ^ 32'h5A5A_0000;
   assign rf_rdata_i  = 32'hC0DE_0000 | {28'd0, rf_raddr_o};

   lsm_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i),
      .base_i(base_i), .base_idx_i(base_idx_i), .load_i(load_i),
      .mode_i(mode_i), .fd_i(fd_i), .wback_i(wback_i), .abort_i(abort_i),
      .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i),
      .rf_rdata_i(rf_rdata_i), .busy_o(busy_o), .req_valid_o(req_valid_o),
      .req_write_o(req_write_o), .req_addr_o(req_addr_o),
      .req_reg_o(req_reg_o), .req_wdata_o(req_wdata_o),
      .rf_raddr_o(rf_raddr_o), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
      .rf_wdata_o(rf_wdata_o), .done_o(done_o), .base_we_o(base_we_o),
      .base_new_o(base_new_o), .align_fault_o(align_fault_o),
      .conflict_o(conflict_o)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // behavioural reference: one instruction, checked every cycle
   task automatic run_op(input logic [15:0] m, input logic [31:0] b, input logic [3:0] bi,
                         input bit ld, input logic [1:0] md, input bit fd, input bit wb,
                         input int stall_every, input int abort_at, input bit poke_start);
      int regs[$];
      int n;
      int emd;
      logic [31:0] first, fin, a;
      bit fault, conf, rdy;
      int k, cyc;
      for (int r = 0; r < 16; r++) if (m[r]) regs.push_back(r);
      n = regs.size();
      emd = fd ? (ld ? 0 : 3) : int'(md);
      case (emd)
         0: begin first = b;             fin = b + 4*n; end
         1: begin first = b + 4;         fin = b + 4*n; end
         2: begin first = b - 4*n + 4;   fin = b - 4*n; end
         default: begin first = b - 4*n; fin = b - 4*n; end
      endcase
      fault = (b[1:0] != 2'b00);
      conf  = wb && m[bi];

      @(negedge clk);
      start_i = 1; mask_i = m; base_i = b; base_idx_i = bi; load_i = ld;
      mode_i = md; fd_i = fd; wback_i = wb; mem_ready_i = 1; abort_i = 0;
      @(posedge clk);
      @(negedge clk);
      start_i = 0;

      if (fault || n == 0) begin
         chk(done_o == 1, fault ? "R9 done" : "R8 done", done_o, 1);
         chk(req_valid_o == 0 && busy_o == 0, fault ? "R9 no request" : "R8 no request", req_valid_o, 0);
         chk(align_fault_o == fault, "R9 fault flag", align_fault_o, fault);
         chk(base_we_o == 0, fault ? "R9 no writeback" : "R8 no writeback", base_we_o, 0);
         chk(conflict_o == conf, "R10 conflict", conflict_o, conf);
         @(negedge clk);
         chk(done_o == 0 && req_valid_o == 0, "R8 single pulse", done_o, 0);
         return;
      end

      k = 0; cyc = 0; a = first;
      while (k < n) begin
         chk(busy_o == 1 && req_valid_o == 1, "R12 busy", busy_o, 1);
         chk(done_o == 0, "R7 no early done", done_o, 0);
         chk(req_reg_o == 4'(regs[k]), "R4 register order", req_reg_o, regs[k]);
         chk(req_addr_o == a, (k == 0) ? "R2 first address" : "R4 address step", req_addr_o, a);
         chk(req_write_o == !ld, "R3 direction", req_write_o, !ld);
         chk(conflict_o == conf, "R10 conflict", conflict_o, conf);
         if (!ld) chk(req_wdata_o == (32'hC0DE_0000 | regs[k]), "R6 store data", req_wdata_o, 32'hC0DE_0000 | regs[k]);
         start_i = (poke_start && cyc == 1);
         if (poke_start && cyc == 1) begin mask_i = 16'h0001; base_i = 32'h100; end
         if (abort_at == cyc) begin
            abort_i = 1; mem_ready_i = 0;
            @(posedge clk);
            @(negedge clk);
            abort_i = 0; mem_ready_i = 1;
            chk(busy_o == 0 && req_valid_o == 0, "R11 abort stops", busy_o, 0);
            chk(done_o == 0 && base_we_o == 0, "R11 abort no commit", {done_o, base_we_o}, 0);
            chk(conflict_o == 0, "R11 abort clears conflict", conflict_o, 0);
            return;
         end
         rdy = !(stall_every > 0 && (cyc % stall_every) == 1);
         mem_ready_i = rdy;
         #1;
         chk(rf_we_o == (rdy && ld), "R6 rf write enable", rf_we_o, rdy && ld);
         if (rdy && ld) begin
            chk(rf_waddr_o == 4'(regs[k]), "R6 rf write index", rf_waddr_o, regs[k]);
            chk(rf_wdata_o == (a ^ 32'h5A5A_0000), "R6 rf write data", rf_wdata_o, a ^ 32'h5A5A_0000);
         end
         @(posedge clk);
         @(negedge clk);
         start_i = 0; mem_ready_i = 1;
         if (rdy) begin k++; a = a + 4; end
         else chk(req_addr_o == a && req_reg_o == 4'(regs[k]), "R5 stall hold", req_addr_o, a);
         cyc++;
      end
      chk(done_o == 1 && busy_o == 0 && req_valid_o == 0, "R7 done after last", done_o, 1);
      chk(base_we_o == wb, "R7 writeback enable", base_we_o, wb);
      if (wb) chk(base_new_o == fin, "R2 updated base", base_new_o, fin);
      chk(conflict_o == conf, "R10 conflict at done", conflict_o, conf);
      chk(align_fault_o == 0, "R9 no fault", align_fault_o, 0);
      @(negedge clk);
      chk(done_o == 0 && base_we_o == 0 && conflict_o == 0, "R7 single pulse", {done_o, base_we_o, conflict_o}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(busy_o == 0 && req_valid_o == 0 && done_o == 0, "R1 reset idle", {busy_o, req_valid_o, done_o}, 0);
      chk(base_we_o == 0 && conflict_o == 0 && align_fault_o == 0, "R1 reset flags", {base_we_o, conflict_o, align_fault_o}, 0);
      rst_n = 1;
      @(negedge clk);
      // R3: stack push with mode_i set to an unrelated code, then the matching pop
      run_op(16'h80F0, 32'h1000, 4'd13, 0, 2'd1, 1, 1, 0, -1, 0);
      run_op(16'h80F0, 32'h0FEC, 4'd13, 1, 2'd2, 1, 1, 0, -1, 0);
      // R2: each discipline code, with stalls (R5)
      run_op(16'h0005, 32'h0200, 4'd0, 1, 2'd1, 0, 0, 2, -1, 0);
      run_op(16'hFFFF, 32'h0400, 4'd0, 0, 2'd2, 0, 1, 3, -1, 1);  // R12 start while busy
      run_op(16'h8001, 32'h0300, 4'd2, 0, 2'd0, 0, 1, 0, -1, 0);
      run_op(16'h0A0A, 32'h0800, 4'd2, 1, 2'd3, 0, 1, 2, -1, 0);
      // R8 empty mask, R9 misaligned base
      run_op(16'h0000, 32'h0500, 4'd0, 0, 2'd0, 0, 1, 0, -1, 0);
      run_op(16'h0011, 32'h1002, 4'd0, 0, 2'd0, 0, 1, 0, -1, 0);
      // R10 base in list with and without write-back
      run_op(16'h2101, 32'h0600, 4'd13, 0, 2'd3, 0, 1, 0, -1, 0);
      run_op(16'h2101, 32'h0600, 4'd13, 0, 2'd3, 0, 0, 0, -1, 0);
      // R11 abort then restart from the beginning
      run_op(16'h00FF, 32'h0700, 4'd13, 0, 2'd3, 1, 1, 0, 2, 0);
      run_op(16'h00FF, 32'h0700, 4'd13, 0, 2'd3, 1, 1, 0, -1, 0);
      run_op(16'h0F00, 32'h0900, 4'd1, 1, 2'd0, 0, 1, 0, 0, 0);
      run_op(16'h0F00, 32'h0900, 4'd1, 1, 2'd0, 0, 1, 2, -1, 0);
      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule